// File: doc/BRIEF.md
# Boot ROM Chip-Select Decoder

This block sits beside a processor's host bus and decides when the boot firmware memory drives the data bus. It watches each bus cycle as the address strobe announces it. It matches the address against two windows. The first is the top 64 KB of the 4 GB space, which holds the reset vector at FFFFFFF0h. The second is the 64 KB real-mode compatibility window from 000F0000h to 000FFFFFh. On a match it drives an active-low chip select to the firmware device. It also drives an active-low output enable, but only when the cycle is a memory read. Code fetches and data reads are treated alike, so only the memory/IO and read/write qualifiers enter the decode.

A one-bit shadow setting is written through a small register port. Once the firmware has been copied into RAM, software sets this bit. From then on, cycles that hit the low window no longer select the firmware device and raise a shadow-RAM select instead. The high window is never shadowed, so the reset vector always reaches the device.

Each decode is captured on the clock edge that samples the strobe. It is held unchanged through any number of wait states, and released on the edge that samples the final ready. Another strobe while a cycle is open is ignored. A configuration write affects only cycles strobed after it.

Top module: `boot_rom_select`

## Requirements
- R1: After reset, rom_cs_n and rom_oe_n are 1, shadow_sel is 0 and the shadow setting is 0.
- R2: A memory cycle strobed with address bits [31:16] equal to FFFFh drives rom_cs_n to 0 from the next clock. This includes the reset-vector code fetch at FFFFFFF0h.
- R3: A memory cycle strobed with an address from 000F0000h to 000FFFFFh, while the shadow setting is 0, drives rom_cs_n to 0 from the next clock.
- R4: While the shadow setting is 1, a memory cycle in the low window leaves rom_cs_n at 1 and rom_oe_n at 1, and drives shadow_sel to 1 instead.
- R5: The shadow setting has no effect on cycles in the high window.
- R6: rom_oe_n goes to 0 only for a memory read (cyc_is_mem=1, cyc_is_write=0) that selects the firmware device. It stays at 1 for writes, for IO cycles and for cycles that select nothing.
- R7: Outputs hold their value for as long as cyc_ready is 0. The clock edge that samples cyc_ready=1 returns all outputs to inactive.
- R8: A cyc_strobe that arrives while a cycle is open is ignored, and the outputs keep the decode of the open cycle.
- R9: On a clock edge with cfg_we=1 the shadow setting takes cfg_wdata. The new value applies only to cycles strobed on later edges, and both setting and clearing work.
- R10: Addresses outside both windows (for example 000EFFFFh, 00100000h, FFFEFFFFh) select nothing.
- R11: An IO cycle (cyc_is_mem=0) selects nothing, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_addr | input | 32 | Physical address of the cycle, sampled with the strobe |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = IO cycle |
| cyc_is_write | input | 1 | 1 = write, 0 = read (code or data) |
| cyc_strobe | input | 1 | Address strobe; starts a cycle when no cycle is open |
| cyc_ready | input | 1 | Final ready; ends the open cycle |
| cfg_we | input | 1 | Write strobe for the shadow setting |
| cfg_wdata | input | 1 | New value of the shadow setting |
| rom_cs_n | output | 1 | Active-low firmware device chip select |
| rom_oe_n | output | 1 | Active-low firmware device output enable |
| shadow_sel | output | 1 | Active-high shadow RAM select |

## Verification
The hardest situations to reach are those where two events overlap an open cycle. In one, a configuration write lands during wait states; in the other, a second strobe arrives before the final ready. In both cases the outputs must keep the decode captured at the start. The bench holds cyc_ready low for several cycles on purpose. It uses that gap to pulse cfg_we, or to strobe a different address, and checks the outputs on every wait cycle. Then it runs a fresh cycle to show that the write took effect only afterwards.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  localparam int ADDR_W       = 32;
  localparam int N_WIN        = 2;
  localparam int WIN_SIZE_LOG = 16;
  localparam logic [ADDR_W-1:0] HIGH_BASE = {{(ADDR_W-WIN_SIZE_LOG){1'b1}}, {WIN_SIZE_LOG{1'b0}}};
  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h000F_0000;
  localparam logic [ADDR_W-1:0] WIN_MASK  = {{(ADDR_W-WIN_SIZE_LOG){1'b1}}, {WIN_SIZE_LOG{1'b0}}};

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic              shadowable;
  } win_t;

  // Window 0: top of the 4 GB space (reset vector); window 1: real-mode area.
  function automatic win_t win_cfg(int idx);
    win_t w;
    w.mask = WIN_MASK;
    if (idx == 0) begin
      w.base       = HIGH_BASE;
      w.shadowable = 1'b0;
    end else begin
      w.base       = LOW_BASE;
      w.shadowable = 1'b1;
    end
    return w;
  endfunction

  function automatic logic win_match(logic [ADDR_W-1:0] a, win_t w);
    return (a & w.mask) == w.base;
  endfunction

  function automatic logic rom_read_kind(logic is_mem, logic is_write);
    return is_mem & ~is_write;
  endfunction
endpackage

// File: rtl/shadow_cfg.sv
module shadow_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic shadow_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow_en <= 1'b0;
    else if (we) shadow_en <= wdata;
  end

  p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> shadow_en == $past(wdata));
  p_cfg_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(shadow_en));
endmodule

// File: rtl/window_decode.sv
module window_decode
  import bootsel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  logic              shadow_en,
  output logic              rom_hit,
  output logic              shadow_hit
);
  logic [N_WIN-1:0] raw_hit, rom_lane, shd_lane;

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    localparam win_t W = win_cfg(k);
    logic diverted;
    assign raw_hit[k]  = win_match(addr, W) & is_mem;
    assign diverted    = W.shadowable & shadow_en;
    assign rom_lane[k] = raw_hit[k] & ~diverted;
    assign shd_lane[k] = raw_hit[k] &  diverted;
  end

  assign rom_hit    = |rom_lane;
  assign shadow_hit = |shd_lane;

  always_comb begin
    p_win_disjoint_r10: assert ($onehot0(raw_hit));
    p_hit_excl_r4: assert (!(rom_hit && shadow_hit));
  end
endmodule

// File: rtl/cycle_tracker.sv
module cycle_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic ready,
  input  logic rom_hit,
  input  logic read_ok,
  input  logic shadow_hit,
  output logic active,
  output logic cs_q,
  output logic oe_q,
  output logic sh_q
);
  logic start, done;
  assign start = strobe & ~active;
  assign done  = active & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cs_q   <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cs_q   <= rom_hit;
      oe_q   <= rom_hit & read_ok;
      sh_q   <= shadow_hit;
    end else if (done) begin
      active <= 1'b0;
      cs_q   <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= 1'b0;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !active) |=> active);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ready) |=> (active && $stable(cs_q) && $stable(oe_q) && $stable(sh_q)));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ready) |=> (!active && !cs_q && !oe_q && !sh_q));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!cs_q && !oe_q && !sh_q));
endmodule

// File: rtl/boot_rom_select.sv
module boot_rom_select
  import bootsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_is_mem,
  input  logic              cyc_is_write,
  input  logic              cyc_strobe,
  input  logic              cyc_ready,
  input  logic              cfg_we,
  input  logic              cfg_wdata,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic              shadow_sel
);
  logic shadow_en, rom_hit, shadow_hit, read_ok;
  logic active, cs_q, oe_q, sh_q;

  shadow_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .shadow_en(shadow_en)
  );

  window_decode u_dec (
    .addr(cyc_addr), .is_mem(cyc_is_mem), .shadow_en(shadow_en),
    .rom_hit(rom_hit), .shadow_hit(shadow_hit)
  );

  assign read_ok = rom_read_kind(cyc_is_mem, cyc_is_write);

  cycle_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .strobe(cyc_strobe), .ready(cyc_ready),
    .rom_hit(rom_hit), .read_ok(read_ok), .shadow_hit(shadow_hit),
    .active(active), .cs_q(cs_q), .oe_q(oe_q), .sh_q(sh_q)
  );

  assign rom_cs_n   = ~cs_q;
  assign rom_oe_n   = ~oe_q;
  assign shadow_sel = sh_q;

  p_oe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_cs_n);
  p_no_write_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !active && (cyc_is_write || !cyc_is_mem)) |=> rom_oe_n);
  p_io_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_strobe && !active && !cyc_is_mem) |=> (rom_cs_n && !shadow_sel));
  p_sel_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && shadow_sel));
endmodule

// File: tb/boot_rom_select_tb.sv
module boot_rom_select_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_is_mem = 1'b0, cyc_is_write = 1'b0;
  logic        cyc_strobe = 1'b0, cyc_ready = 1'b0;
  logic        cfg_we = 1'b0, cfg_wdata = 1'b0;
  logic        rom_cs_n, rom_oe_n, shadow_sel;
  int          checks = 0, errors = 0;
  bit          model_shadow = 1'b0;

  always #5 clk = ~clk;

  boot_rom_select u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_addr(cyc_addr), .cyc_is_mem(cyc_is_mem),
    .cyc_is_write(cyc_is_write), .cyc_strobe(cyc_strobe), .cyc_ready(cyc_ready),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .shadow_sel(shadow_sel)
  );

  function automatic bit in_top(logic [31:0] a);
    return a >= 32'hFFFF_0000;
  endfunction
  function automatic bit in_real(logic [31:0] a);
    return (a >= 32'h000F_0000) && (a <= 32'h000F_FFFF);
  endfunction

  task automatic check3(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {cs_n,oe_n,sh} got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [2:0] expect_vec(logic [31:0] a, bit mem, bit wr, bit shd);
    bit cs, sh;
    cs = mem && (in_top(a) || (in_real(a) && !shd));
    sh = mem && in_real(a) && shd;
    return {~cs, ~(cs && !wr), sh};
  endfunction

  task automatic cfg_write(bit v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    model_shadow = v;
  endtask

  // One bus cycle with 'waits' wait states; checks every cycle and the release.
  task automatic run_cycle(string req, logic [31:0] a, bit mem, bit wr, int waits);
    logic [2:0] exp;
    exp = expect_vec(a, mem, wr, model_shadow);
    @(negedge clk);
    cyc_addr = a; cyc_is_mem = mem; cyc_is_write = wr;
    cyc_strobe = 1'b1; cyc_ready = 1'b0;
    for (int i = 0; i <= waits; i++) begin
      @(negedge clk);
      cyc_strobe = 1'b0;
      cyc_ready  = (i == waits);
      check3(req, {rom_cs_n, rom_oe_n, shadow_sel}, exp);
    end
    @(negedge clk);
    cyc_ready = 1'b0;
    check3({req, " R7 release"}, {rom_cs_n, rom_oe_n, shadow_sel}, 3'b110);
  endtask

  task automatic t_reset;
    check3("R1 reset outputs", {rom_cs_n, rom_oe_n, shadow_sel}, 3'b110);
    // shadow setting 0 seen at ports: low window selects the device
    run_cycle("R1 shadow resets to 0", 32'h000F_1234, 1, 0, 0);
  endtask

  task automatic t_high;
    run_cycle("R2 reset vector fetch", 32'hFFFF_FFF0, 1, 0, 0);
    run_cycle("R2 high window base", 32'hFFFF_0000, 1, 0, 1);
    run_cycle("R6 high window write", 32'hFFFF_8000, 1, 1, 0);
  endtask

  task automatic t_low;
    run_cycle("R3 low window base", 32'h000F_0000, 1, 0, 0);
    run_cycle("R3 low window top", 32'h000F_FFFF, 1, 0, 2);
    run_cycle("R6 low window write", 32'h000F_E05B, 1, 1, 0);
  endtask

  task automatic t_outside;
    run_cycle("R10 below low window", 32'h000E_FFFF, 1, 0, 0);
    run_cycle("R10 above low window", 32'h0010_0000, 1, 0, 0);
    run_cycle("R10 below high window", 32'hFFFE_FFFF, 1, 0, 0);
  endtask

  task automatic t_io;
    run_cycle("R11 io read at FFFFFFF0", 32'hFFFF_FFF0, 0, 0, 0);
    run_cycle("R11 io write in low range", 32'h000F_0080, 0, 1, 1);
  endtask

  task automatic t_shadow;
    cfg_write(1'b1);
    run_cycle("R4 shadowed low read", 32'h000F_E05B, 1, 0, 1);
    run_cycle("R4 shadowed low write", 32'h000F_0010, 1, 1, 0);
    run_cycle("R5 high window unshadowed", 32'hFFFF_FFF0, 1, 0, 0);
    cfg_write(1'b0);
    run_cycle("R9 clear restores low window", 32'h000F_4000, 1, 0, 0);
  endtask

  task automatic t_restrobe;
    logic [2:0] exp;
    exp = expect_vec(32'hFFFF_FFF0, 1, 0, model_shadow);
    @(negedge clk);
    cyc_addr = 32'hFFFF_FFF0; cyc_is_mem = 1; cyc_is_write = 0; cyc_strobe = 1;
    @(negedge clk);
    cyc_addr = 32'h0010_0000; cyc_is_write = 1; // second strobe, must be ignored
    check3("R8 first decode", {rom_cs_n, rom_oe_n, shadow_sel}, exp);
    @(negedge clk);
    cyc_strobe = 0;
    check3("R8 second strobe ignored", {rom_cs_n, rom_oe_n, shadow_sel}, exp);
    cyc_ready = 1;
    @(negedge clk);
    cyc_ready = 0;
    check3("R8 R7 release", {rom_cs_n, rom_oe_n, shadow_sel}, 3'b110);
  endtask

  task automatic t_midwrite;
    logic [2:0] exp;
    exp = expect_vec(32'h000F_8000, 1, 0, 1'b0);
    @(negedge clk);
    cyc_addr = 32'h000F_8000; cyc_is_mem = 1; cyc_is_write = 0; cyc_strobe = 1;
    @(negedge clk);
    cyc_strobe = 0;
    cfg_we = 1; cfg_wdata = 1;
    check3("R9 before mid write", {rom_cs_n, rom_oe_n, shadow_sel}, exp);
    @(negedge clk);
    cfg_we = 0;
    model_shadow = 1;
    check3("R9 open cycle unaffected", {rom_cs_n, rom_oe_n, shadow_sel}, exp);
    cyc_ready = 1;
    @(negedge clk);
    cyc_ready = 0;
    check3("R9 R7 release", {rom_cs_n, rom_oe_n, shadow_sel}, 3'b110);
    run_cycle("R9 next cycle shadowed", 32'h000F_8000, 1, 0, 0);
    cfg_write(1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high();
    t_low();
    t_outside();
    t_io();
    t_shadow();
    t_restrobe();
    t_midwrite();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule